// File: doc/BRIEF.md
# Switch-Gated Circular Sample Buffer

This block is a circular sample store that sits in a data path which must not lose words while the radio changes its modulation or moves to another carrier. Each pulse on the write strobe stores one word. The block drains itself, one word per cycle, but only while no switch is in progress. There are two sources of "in progress". The first is an external mode-change busy input. The second is an internal settling timer, which a channel-switch request pulse starts and which keeps reads stopped for a programmable number of cycles.

The overflow behaviour is chosen by a parameter. In the transmit policy, the full flag goes back to the data source, which must stop sending. In the receive policy, a sample that arrives while the store is full is thrown away and counted, and the words already held are left untouched. The depth is sized at elaboration so that it can absorb every write that can arrive during one settling interval, given the minimum gap between write strobes.

Top module: `swgate_fifo`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `level`, `rd_valid`, `sw_busy` and `drop_count` are all 0.
- R2: Every write strobe taken while `full` is 0 stores `wr_data`. Stored words come out on `rd_data` in the order they were written.
- R3: A read takes place in a cycle only when all of these hold: the store is not empty, `mode_busy` is 0, `sw_busy` is 0 and `sw_req` is 0. `rd_valid` is 1 in the cycle after that read, with the word on `rd_data`.
- R4: A pulse on `sw_req` makes `sw_busy` 1 for exactly SETTLE_CYC cycles, starting with the cycle after the pulse. A new pulse while `sw_busy` is 1 restarts the full interval.
- R5: `full` is 1 exactly when `level` equals DEPTH. A write strobe while `full` is 1 does not store its word, even if a read happens in the same cycle.
- R6: With the receive policy, each write strobe while `full` is 1 adds one to `drop_count`. The count stops at its maximum value of 2^DROP_W-1.
- R7: With the transmit policy, `drop_count` stays 0 and `full` is the back-pressure flag.
- R8: A write and a read in the same cycle leave `level` unchanged.
- R9: The read and write positions wrap at DEPTH. Word order is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | One pulse per new incoming word |
| wr_data | input | DATA_W | Incoming word |
| mode_busy | input | 1 | Modulation-mode change in progress; holds reads |
| sw_req | input | 1 | Channel-switch request pulse; starts the settling timer |
| rd_valid | output | 1 | `rd_data` carries a word read out in the previous cycle |
| rd_data | output | DATA_W | Word read out |
| level | output | $clog2(DEPTH+1) | Number of words held |
| full | output | 1 | Store holds DEPTH words |
| empty | output | 1 | Store holds no words |
| sw_busy | output | 1 | Settling interval running |
| drop_count | output | DROP_W | Saturating count of discarded samples (receive policy) |

## Verification
Three things can land on the same edge: a write, a read, and the decision about whether that write fits. The case that matters most is a strobe arriving at a full store in the very cycle a hold is released. Here the read frees a slot, but the write is still refused and counted as a drop. A separate case is a read and a write together at partial occupancy, which must leave the level unchanged. The stimulus table sets up both cases on purpose, including a second switch request that arrives while the first interval is still running. Each cycle's outputs are compared against a bench-side model of queue contents, level, settling interval and drop count.

// File: rtl/swg_pkg.sv
package swg_pkg;
   typedef enum logic {
      SWG_TX = 1'b0,
      SWG_RX = 1'b1
   } swg_policy_e;
endpackage

// File: rtl/swg_settle_timer.sv
module swg_settle_timer #(
   parameter int SETTLE_CYC = 64,
   parameter int TMR_W      = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [TMR_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)               remain <= '0;
      else if (start)           remain <= TMR_W'(SETTLE_CYC);
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R4: a request opens the interval on the next cycle
   a_r4_start_busy : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R4: the interval counts down by one each idle cycle
   a_r4_countdown : assert property (@(posedge clk) disable iff (!rst_n)
      (!start && busy) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/swg_ring_store.sv
module swg_ring_store #(
   parameter int DATA_W = 14,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr     <= '0;
         rptr     <= '0;
         level    <= '0;
         pop_data <= '0;
      end else begin
         if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         if (pop) begin
            rptr     <= (rptr == LAST) ? '0 : rptr + 1'b1;
            pop_data <= mem[rptr];
         end
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);

   // R8: concurrent push and pop keep occupancy
   a_r8_level_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(level));
   // R5: caller never pushes into a full store
   a_r5_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R3: caller never pops an empty store
   a_r3_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/swg_drop_counter.sv
module swg_drop_counter #(
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   output logic [DROP_W-1:0] count
);
   localparam logic [DROP_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                  count <= '0;
      else if (hit && count != TOP) count <= count + 1'b1;
   end

   // R6: each discard below the ceiling adds exactly one
   a_r6_drop_step : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && count != TOP) |=> (count == $past(count) + 1'b1));
   // R6: the count holds once at the ceiling
   a_r6_drop_sat : assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/swgate_fifo.sv
module swgate_fifo #(
   parameter int                  DATA_W     = 14,
   parameter int                  DEPTH      = 16,
   parameter int                  SETTLE_CYC = 64,
   parameter int                  MIN_WR_GAP = 4,
   parameter int                  DROP_W     = 8,
   parameter swg_pkg::swg_policy_e POLICY    = swg_pkg::SWG_RX,
   localparam int                 LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mode_busy,
   input  logic              sw_req,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty,
   output logic              sw_busy,
   output logic [DROP_W-1:0] drop_count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int TMR_W = $clog2(SETTLE_CYC + 1);

   initial begin
      a_cfg_depth : assert (DEPTH >= 2)
         else $error("DEPTH must be at least 2");
      a_cfg_absorb : assert (DEPTH * MIN_WR_GAP >= SETTLE_CYC)
         else $error("DEPTH too small to absorb a settling interval");
      a_cfg_widths : assert (DATA_W >= 1 && DROP_W >= 1 && SETTLE_CYC >= 1 && MIN_WR_GAP >= 1)
         else $error("bad width or count parameter");
   end

   logic push, pop;

   assign pop  = !empty && !sw_busy && !mode_busy && !sw_req;
   assign push = wr_strobe && !full;

   swg_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .TMR_W(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sw_req),
      .busy  (sw_busy)
   );

   swg_ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .pop_data  (rd_data),
      .level     (level),
      .full      (full),
      .empty     (empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= pop;
   end

   generate
      if (POLICY == swg_pkg::SWG_RX) begin : g_rx_drop
         swg_drop_counter #(.DROP_W(DROP_W)) u_drop (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (wr_strobe && full),
            .count (drop_count)
         );
      end else begin : g_tx_hold
         assign drop_count = '0;
      end
   endgenerate

   // R3: a delivered word implies the gate was open one cycle earlier
   a_r3_read_gated : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!empty && !sw_busy && !mode_busy && !sw_req));
   // R5: a refused write at full with no read leaves the store full
   a_r5_full_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_strobe && !pop) |=> (full && $stable(level)));
   // R4: no word leaves while the settling interval runs
   a_r4_no_read_busy : assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_busy) |-> !rd_valid);
endmodule

// File: tb/tb_swgate_fifo.sv
module tb_swgate_fifo;
   localparam int DW = 14, D = 4, S = 6, DRW = 3, LW = $clog2(D + 1);
   localparam int NV = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_strobe = 1'b0, mode_busy = 1'b0, sw_req = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic rd_valid, full, empty, sw_busy, t_rd_valid, t_full, t_empty, t_sw_busy;
   logic [DW-1:0] rd_data, t_rd_data;
   logic [LW-1:0] level, t_level;
   logic [DRW-1:0] drop_count, t_drop_count;

   always #4 clk = ~clk;

   swgate_fifo #(.DATA_W(DW), .DEPTH(D), .SETTLE_CYC(S), .MIN_WR_GAP(2), .DROP_W(DRW),
                 .POLICY(swg_pkg::SWG_RX)) dut (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
      .mode_busy(mode_busy), .sw_req(sw_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .level(level), .full(full), .empty(empty), .sw_busy(sw_busy), .drop_count(drop_count));

   swgate_fifo #(.DATA_W(DW), .DEPTH(D), .SETTLE_CYC(S), .MIN_WR_GAP(2), .DROP_W(DRW),
                 .POLICY(swg_pkg::SWG_TX)) dut_tx (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
      .mode_busy(mode_busy), .sw_req(sw_req), .rd_valid(t_rd_valid), .rd_data(t_rd_data),
      .level(t_level), .full(t_full), .empty(t_empty), .sw_busy(t_sw_busy),
      .drop_count(t_drop_count));

   // vector: {wr, data[13:0], mode_busy, sw_req}
   localparam logic [16:0] VEC [NV] = '{
      {1'b1,14'h101,1'b1,1'b0}, {1'b1,14'h102,1'b1,1'b0}, {1'b1,14'h103,1'b1,1'b0},
      {1'b1,14'h104,1'b1,1'b0}, {1'b1,14'h105,1'b1,1'b0}, {1'b1,14'h106,1'b1,1'b0},
      {1'b1,14'h107,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b1,14'h108,1'b0,1'b0},
      {1'b1,14'h109,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b1}, {1'b1,14'h10A,1'b0,1'b0},
      {1'b1,14'h10B,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b1},
      {1'b1,14'h10C,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0},
      {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0},
      {1'b1,14'h10D,1'b0,1'b0}, {1'b1,14'h10E,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0},
      {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0},
      {1'b1,14'h111,1'b1,1'b0}, {1'b1,14'h112,1'b1,1'b0}, {1'b1,14'h113,1'b1,1'b0},
      {1'b1,14'h114,1'b1,1'b0}, {1'b1,14'h115,1'b1,1'b0}, {1'b1,14'h116,1'b1,1'b0},
      {1'b1,14'h117,1'b1,1'b0}, {1'b1,14'h118,1'b1,1'b0}, {1'b1,14'h119,1'b1,1'b0},
      {1'b1,14'h11A,1'b1,1'b0}, {1'b0,14'h000,1'b0,1'b0}, {1'b0,14'h000,1'b0,1'b0},
      {1'b0,14'h000,1'b0,1'b0}
   };

   int checks = 0, fails = 0;
   int mq[$];
   int msettle = 0, mdrop = 0;
   bit done = 1'b0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      mq.delete();
      msettle = 0;
      mdrop = 0;
   endtask

   task automatic check_reset();
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 level", int'(level), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 sw_busy", int'(sw_busy), 0);
      chk("R1 drop_count", int'(drop_count), 0);
      chk("R7 tx drop_count at reset", int'(t_drop_count), 0);
   endtask

   // drive one cycle, predict, check after the edge
   task automatic step(bit wr, int d, bit mb, bit rq);
      bit rd;
      int exp_word;
      @(negedge clk);
      wr_strobe = wr; wr_data = DW'(d); mode_busy = mb; sw_req = rq;
      rd = (mq.size() > 0) && !mb && (msettle == 0) && !rq;
      exp_word = 0;
      if (rd) exp_word = mq.pop_front();
      if (wr && (mq.size() + (rd ? 1 : 0)) < D) mq.push_back(d);
      else if (wr && mdrop < 7) mdrop++;
      if (rq) msettle = S;
      else if (msettle > 0) msettle--;
      @(posedge clk);
      #1;
      chk("R3 rd_valid", int'(rd_valid), int'(rd));
      if (rd) chk("R2/R9 rd_data order", int'(rd_data), exp_word);
      chk("R8 level", int'(level), mq.size());
      chk("R5 full flag", int'(full), int'(mq.size() == D));
      chk("R4 sw_busy", int'(sw_busy), int'(msettle != 0));
      chk("R6 drop_count", int'(drop_count), mdrop);
      chk("R7 tx level", int'(t_level), mq.size());
      chk("R7 tx full", int'(t_full), int'(mq.size() == D));
      chk("R7 tx drop_count", int'(t_drop_count), 0);
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();

      // table walk: fill under hold, drops, release at full, settle, re-request, wrap
      for (int i = 0; i < NV; i++)
         step(VEC[i][16], int'(VEC[i][15:2]), VEC[i][1], VEC[i][0]);

      // R4: settle length, exactly S busy cycles then a read resumes
      step(1'b1, 14'h1A0, 1'b0, 1'b1);
      for (int k = 0; k < S; k++) step(1'b0, 0, 1'b0, 1'b0);
      step(1'b0, 0, 1'b0, 1'b0);

      // R6: saturation already reached in table; more drops keep it at ceiling
      for (int k = 0; k < 5; k++) step(1'b1, 14'h1B0 + k, 1'b1, 1'b0);
      chk("R6 saturated at ceiling", int'(drop_count), 7);

      // R1: reset in the middle of traffic
      @(negedge clk);
      rst_n = 1'b0;
      wr_strobe = 1'b0; mode_busy = 1'b0; sw_req = 1'b0;
      @(posedge clk);
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      step(1'b1, 14'h2C0, 1'b0, 1'b0);
      step(1'b0, 0, 1'b0, 1'b0);
      step(1'b0, 0, 1'b0, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule